// File: doc/BRIEF.md
# Framed Doubling Stream Stage

This block sits in a streaming pipeline between an upstream producer and a downstream consumer. Each word taken from the upstream stream is multiplied by two, truncated to the data width, and forwarded downstream. Both sides use the AXI4-Stream handshake. The data, byte-keep, user flag, end-of-frame flag, valid and ready are all separate ports.

The block does not copy the side-channel fields from its input. It generates them from an internal beat index. The keep bits are always all ones. The user flag marks every even-indexed beat. The end-of-frame flag closes a fixed frame of ten beats, and frames then repeat without limit. A single output register holds the outgoing word. The upstream ready is derived from that register and the downstream ready, so a stall downstream reaches the producer and a free-flowing pipe moves one word per cycle.

Top module: `strm_dbl_framer`

## Requirements
- R1: When an input word d is accepted, the output word is (2*d) mod 65536. Bit 15 of d is discarded and bit 0 of the result is 0.
- R2: Whenever `m_tvalid` is 1, `m_tkeep` equals 2'b11.
- R3: The beat index counts completed output transfers since reset, modulo 10. `m_tuser` is 1 when the index of the beat on the output is even and 0 when it is odd.
- R4: `m_tlast` is 1 only on the beat whose index is 9. The beat after it has index 0.
- R5: A transfer happens on a side only in a cycle where its valid and ready are both 1. While `m_tvalid` is 1 and `m_tready` is 0, `m_tdata`, `m_tkeep`, `m_tuser` and `m_tlast` hold their values and the beat index does not advance.
- R6: `s_tready` is 1 exactly when `m_tready` is 1 or `m_tvalid` is 0. An input offered during a downstream stall is therefore not taken until the stall ends.
- R7: A word accepted at a rising edge is on the output, with `m_tvalid` at 1, after that same edge. With `m_tready` held at 1 and a continuous input, one word passes every cycle and `s_tready` never drops.
- R8: A synchronous active-high `rst` clears `m_tvalid` and sets the beat index to 0, so the first beat after reset has `m_tuser` 1 and `m_tlast` 0.
- R9: The input keep bits, user flag and end-of-frame flag have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 16 | Upstream data word |
| s_tkeep | input | 2 | Upstream keep bits (not used) |
| s_tuser | input | 1 | Upstream user flag (not used) |
| s_tlast | input | 1 | Upstream end-of-frame flag (not used) |
| s_tvalid | input | 1 | Upstream word is offered |
| s_tready | output | 1 | Stage can take a word this cycle |
| m_tdata | output | 16 | Doubled data word |
| m_tkeep | output | 2 | Keep bits, always 2'b11 |
| m_tuser | output | 1 | 1 on even-indexed beats of the frame |
| m_tlast | output | 1 | 1 on the tenth beat of the frame |
| m_tvalid | output | 1 | Output word is valid |
| m_tready | input | 1 | Downstream takes the word this cycle |

## Verification
A word accepted at a rising edge is due on the output one edge later. The beat-index fields change only at the edge that completes an output transfer. `s_tready` follows `m_tready` and `m_tvalid` with no clock between them. The bench drives every input on the falling edge and samples at the next falling edge. At that point one rising edge has passed, so the doubled word and its keep, user and last fields are read in the cycle they are due. `s_tready` is read in the same half cycle as the inputs that set it. The expected beat index comes from a bench counter that advances on each observed output handshake. A stalled or wrongly advancing index therefore shows up as a wrong user or last flag on the next beat.

// File: rtl/dblfrm_pkg.sv
package dblfrm_pkg;

    localparam int unsigned DFLT_DATA_W      = 16;
    localparam int unsigned DFLT_FRAME_BEATS = 10;

    // Side-channel flags carried with each outgoing beat
    typedef struct packed {
        logic user;
        logic last;
    } side_t;

    // Flags for the beat at position idx of a frame of frame_beats beats
    function automatic side_t make_side(input int unsigned idx,
                                        input int unsigned frame_beats);
        side_t s;
        s.user = ((idx & 32'd1) == 32'd0);
        s.last = (idx == frame_beats - 1);
        return s;
    endfunction

endpackage

// File: rtl/dblfrm_beat_ctr.sv
module dblfrm_beat_ctr #(
    parameter int unsigned FRAME_BEATS = 10,
    parameter int unsigned IDX_W       = $clog2(FRAME_BEATS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BEATS - 1);

    generate
        if ((FRAME_BEATS & (FRAME_BEATS - 1)) == 0) begin : g_pow2
            // natural wrap of the counter width
            always_ff @(posedge clk) begin
                if (rst)      idx <= '0;
                else if (adv) idx <= idx + 1'b1;
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)      idx <= '0;
                else if (adv) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/dblfrm_side_gen.sv
module dblfrm_side_gen
    import dblfrm_pkg::*;
#(
    parameter int unsigned FRAME_BEATS = 10,
    parameter int unsigned IDX_W       = $clog2(FRAME_BEATS),
    parameter int unsigned KEEP_W      = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [KEEP_W-1:0] keep,
    output side_t             side
);
    always_comb begin
        keep = '1;
        side = make_side(32'(idx), FRAME_BEATS);
    end
endmodule

// File: rtl/dblfrm_out_stage.sv
module dblfrm_out_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    logic load;

    assign in_ready = out_ready | ~out_valid;
    assign load     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) out_data <= {in_data[DATA_W-2:0], 1'b0};
    end
endmodule

// File: rtl/strm_dbl_framer.sv
module strm_dbl_framer
    import dblfrm_pkg::*;
#(
    parameter int unsigned DATA_W      = DFLT_DATA_W,
    parameter int unsigned FRAME_BEATS = DFLT_FRAME_BEATS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [DATA_W/8-1:0] s_tkeep,
    input  logic                s_tuser,
    input  logic                s_tlast,
    input  logic                s_tvalid,
    output logic                s_tready,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic                m_tuser,
    output logic                m_tlast,
    output logic                m_tvalid,
    input  logic                m_tready
);
    localparam int unsigned KEEP_W = DATA_W / 8;
    localparam int unsigned IDX_W  = $clog2(FRAME_BEATS);

    logic [IDX_W-1:0] beat_idx;
    side_t            side;
    logic             out_fire;
    logic             unused_side_in;

    // input side channels are deliberately dropped
    assign unused_side_in = ^{s_tkeep, s_tuser, s_tlast};

    dblfrm_out_stage #(.DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_tvalid),
        .in_data  (s_tdata),
        .in_ready (s_tready),
        .out_valid(m_tvalid),
        .out_data (m_tdata),
        .out_ready(m_tready)
    );

    assign out_fire = m_tvalid & m_tready;

    dblfrm_beat_ctr #(.FRAME_BEATS(FRAME_BEATS), .IDX_W(IDX_W)) u_ctr (
        .clk(clk),
        .rst(rst),
        .adv(out_fire),
        .idx(beat_idx)
    );

    dblfrm_side_gen #(.FRAME_BEATS(FRAME_BEATS), .IDX_W(IDX_W), .KEEP_W(KEEP_W)) u_side (
        .idx (beat_idx),
        .keep(m_tkeep),
        .side(side)
    );

    assign m_tuser = side.user;
    assign m_tlast = side.last;

endmodule

// File: rtl/dblfrm_chk.sv
module dblfrm_chk #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned FRAME_BEATS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic [DATA_W-1:0]   s_tdata,
    input logic                s_tvalid,
    input logic                s_tready,
    input logic [DATA_W-1:0]   m_tdata,
    input logic [DATA_W/8-1:0] m_tkeep,
    input logic                m_tuser,
    input logic                m_tlast,
    input logic                m_tvalid,
    input logic                m_tready
);
    localparam int unsigned IDX_W = $clog2(FRAME_BEATS);

    // independent count of output handshakes
    logic [IDX_W-1:0] seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (m_tvalid && m_tready)
            seen <= (seen == IDX_W'(FRAME_BEATS - 1)) ? '0 : seen + 1'b1;
    end

    a_r1_doubled: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> (m_tvalid && m_tdata == DATA_W'($past(s_tdata) << 1)));

    a_r2_keep_full: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tkeep == '1));

    a_r3_user_even: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tuser == ~seen[0]));

    a_r4_last_pos: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tlast == (seen == IDX_W'(FRAME_BEATS - 1))));

    a_r4_after_last: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast && s_tvalid) |=> m_tuser);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser)
                                      && $stable(m_tlast) && $stable(m_tkeep)));

    a_r6_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |-> !s_tready);

    a_r8_reset: assert property (@(posedge clk)
        rst |=> (!m_tvalid && s_tready));

endmodule

bind strm_dbl_framer dblfrm_chk #(.DATA_W(DATA_W), .FRAME_BEATS(FRAME_BEATS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_tdata (s_tdata),
    .s_tvalid(s_tvalid),
    .s_tready(s_tready),
    .m_tdata (m_tdata),
    .m_tkeep (m_tkeep),
    .m_tuser (m_tuser),
    .m_tlast (m_tlast),
    .m_tvalid(m_tvalid),
    .m_tready(m_tready)
);

// File: tb/sim_strm_dbl_framer.sv
module sim_strm_dbl_framer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] s_tdata = '0;
    logic [1:0]  s_tkeep = 2'b11;
    logic        s_tuser = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [15:0] m_tdata;
    logic [1:0]  m_tkeep;
    logic        m_tuser;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b1;

    int checks = 0;
    int errors = 0;
    int exp_idx = 0;

    always #2 clk = ~clk;   // 250 MHz

    strm_dbl_framer u0 (
        .clk(clk), .rst(rst),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    // beat index model: output handshakes since reset, modulo 10 (R3, R4)
    always @(posedge clk) begin
        if (rst) exp_idx <= 0;
        else if (m_tvalid && m_tready) exp_idx <= (exp_idx == 9) ? 0 : exp_idx + 1;
    end

    function automatic logic [15:0] dbl(input logic [15:0] d);
        return 16'((32'(d) * 2) % 65536);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // sampled at a falling edge where a beat is due on the output
    task automatic expect_beat(input logic [15:0] d);
        chk(m_tvalid === 1'b1, "R7 valid", int'(m_tvalid), 1);
        chk(m_tdata === dbl(d), "R1 data", int'(m_tdata), int'(dbl(d)));
        chk(m_tkeep === 2'b11, "R2 keep", int'(m_tkeep), 3);
        chk(m_tuser === ((exp_idx % 2) == 0), "R3 user", int'(m_tuser), int'((exp_idx % 2) == 0));
        chk(m_tlast === (exp_idx == 9), "R4 last", int'(m_tlast), int'(exp_idx == 9));
    endtask

    task automatic t_reset();
        rst = 1'b1; s_tvalid = 1'b0; m_tready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(m_tvalid === 1'b0, "R8 valid cleared", int'(m_tvalid), 0);
        chk(s_tready === 1'b1, "R6 ready when empty", int'(s_tready), 1);
        rst = 1'b0; m_tready = 1'b1;
    endtask

    // continuous stream with downstream always ready
    task automatic t_stream(input int n, input logic [15:0] seed, input bit scramble_side);
        m_tready = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = seed + 16'(i * 16'h2F1B);
            s_tvalid = 1'b1; s_tdata = w;
            if (scramble_side) begin   // R9: must not matter
                s_tkeep = 2'(i); s_tuser = ~exp_idx[0]; s_tlast = (i % 3 == 0);
            end
            @(negedge clk);
            expect_beat(w);
            if (scramble_side) chk(m_tkeep === 2'b11, "R9 keep ignored", int'(m_tkeep), 3);
            chk(s_tready === 1'b1, "R7 no bubble", int'(s_tready), 1);
        end
        s_tvalid = 1'b0; s_tkeep = 2'b11; s_tuser = 1'b0; s_tlast = 1'b0;
        @(negedge clk);
        chk(m_tvalid === 1'b0, "R5 drains when idle", int'(m_tvalid), 0);
    endtask

    task automatic t_stall();
        logic [15:0] a, b, first_d;
        a = 16'h4321; b = 16'hC0DE;
        m_tready = 1'b0; s_tvalid = 1'b1; s_tdata = a;
        @(negedge clk);
        expect_beat(a);
        first_d = m_tdata;
        s_tdata = b;   // offered during stall, must wait
        for (int k = 0; k < 3; k++) begin
            chk(s_tready === 1'b0, "R6 stall reaches upstream", int'(s_tready), 0);
            @(negedge clk);
            chk(m_tdata === first_d, "R5 data held", int'(m_tdata), int'(first_d));
            expect_beat(a);
        end
        m_tready = 1'b1;
        @(negedge clk);
        expect_beat(b);
        s_tvalid = 1'b0;
        @(negedge clk);
        chk(m_tvalid === 1'b0, "R5 no transfer without valid", int'(m_tvalid), 0);
    endtask

    task automatic t_reset_mid();
        t_stream(4, 16'h0100, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(m_tvalid === 1'b0, "R8 mid-frame reset", int'(m_tvalid), 0);
        s_tvalid = 1'b1; s_tdata = 16'h0005;
        @(negedge clk);
        chk(m_tuser === 1'b1 && m_tlast === 1'b0, "R8 index restarts",
            int'({m_tuser, m_tlast}), 2);
        s_tvalid = 1'b0;
        @(negedge clk);
        t_stream(10, 16'h0A00, 1'b0);   // indices 1..9 then 0 (R4)
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        @(negedge clk);
        t_reset();
        t_stream(25, 16'h0001, 1'b0);     // wraps frames, R3 R4 R7
        t_stream(3, 16'h8001, 1'b0);      // truncation of bit 15, R1
        t_stream(2, 16'hFFFF, 1'b0);      // R1 top value
        t_stall();                        // R5 R6
        t_stream(12, 16'h1234, 1'b1);     // R9 side inputs scrambled
        t_reset_mid();                    // R8
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule